// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the order of column addresses that an SDRAM's internal burst counter walks through during one read or write burst. A controller strobes `start` together with a starting column, a burst length code and an ordering bit. From the next clock on, the block emits one column address per cycle. Each address comes with a valid flag, and a last flag marks the final address of a bounded burst.

Bursts of 2, 4 or 8 stay inside the naturally aligned block of that size that holds the starting column. Only the low offset bits move, and the column bits above the block stay fixed. The offset either counts upward and wraps, or is formed as the start offset XOR the beat number. A full-row burst counts upward through every column of the row, wraps at the row end and continues without limit. The controller ends it with `stop` or replaces it with a new `start`. A new `start` is accepted on any clock and cuts off whatever burst is running.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `col_valid`, `col_last` and `len_err` are all 0.
- R2: A `start` sampled on a clock edge makes the next cycle show `col_valid`=1 and `col_out` equal to `start_col`. A new address follows on each later cycle of the burst.
- R3: `len_code` selects the burst length: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives a full row. A bounded burst of length N shows exactly N valid cycles.
- R4: With `interleave`=0 and length N of 2, 4 or 8, beat i carries the low offset ((start mod N) + i) mod N. The column bits above the block equal those of `start_col`.
- R5: With `interleave`=1 and length N of 2, 4 or 8, beat i carries the low offset (start mod N) XOR i. The upper bits are held as in R4.
- R6: `col_last` is 1 on the final beat of a bounded burst and on no other beat. When no new `start` is given, `col_valid` is 0 on the cycle after that beat.
- R7: In full-row mode (code 7), beat i is (start_col + i) mod 2^COL_W whatever `interleave` is. `col_last` never rises, and the burst keeps running past the row end.
- R8: `stop` sampled without `start` makes `col_valid` 0 on the next cycle. When `stop` and `start` arrive on the same edge, `start` wins.
- R9: A `start` during a running burst drops the old sequence. The next cycle shows the new column, and the new burst continues from there.
- R10: Codes 4, 5 and 6 are reserved. They run a single-beat burst (with `col_last`=1) and set `len_err`=1. `len_err` holds that value until the next accepted `start` loads a fresh one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new burst, sampled each edge |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Burst length code (see R3, R10) |
| interleave | input | 1 | 1 selects XOR ordering, 0 selects counting order |
| stop | input | 1 | Terminate the running burst |
| col_out | output | COL_W | Current column address |
| col_valid | output | 1 | `col_out` holds a burst address |
| col_last | output | 1 | Final address of a bounded burst |
| len_err | output | 1 | The current burst came from a reserved code |

## Verification
Every output comes from one register stage. The first address, the error flag and the last flag of a one-beat burst all show in the cycle right after the `start` edge. Each later beat appears one cycle after the one before it. After a final beat or a `stop`, `col_valid` falls in the next cycle. The bench drives every input on the falling edge and reads the outputs on the following falling edge, so every edge advances exactly one beat. Expected addresses come from block-base plus modulo arithmetic in the bench, and one reading is compared per beat.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam logic [2:0] LEN_ONE   = 3'd0;
  localparam logic [2:0] LEN_TWO   = 3'd1;
  localparam logic [2:0] LEN_FOUR  = 3'd2;
  localparam logic [2:0] LEN_EIGHT = 3'd3;
  localparam logic [2:0] LEN_ROW   = 3'd7;

  typedef struct packed {
    logic [1:0] shift;  // log2 of bounded length
    logic       row;    // full-row burst
    logic       bad;    // reserved code seen
  } len_info_t;

  function automatic len_info_t decode_len(input logic [2:0] code);
    len_info_t r;
    r = '{shift: 2'd0, row: 1'b0, bad: 1'b0};
    case (code)
      LEN_ONE:   r.shift = 2'd0;
      LEN_TWO:   r.shift = 2'd1;
      LEN_FOUR:  r.shift = 2'd2;
      LEN_EIGHT: r.shift = 2'd3;
      LEN_ROW:   r.row   = 1'b1;
      default:   r.bad   = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/burst_col_lendec.sv
module burst_col_lendec
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [2:0]       code,
  input  logic             il_req,
  output logic [COL_W-1:0] mask,
  output logic             il_eff,
  output logic             row,
  output logic             bad
);
  function automatic logic [COL_W-1:0] make_mask(input logic [1:0] sh, input logic pg);
    if (pg) return '1;
    return (COL_W'(1) << sh) - COL_W'(1);
  endfunction

  len_info_t info;

  always_comb begin
    info   = decode_len(code);
    mask   = make_mask(info.shift, info.row);
    row    = info.row;
    bad    = info.bad;
    il_eff = il_req & ~info.row;   // full-row bursts count upward only
  end
endmodule

// File: rtl/burst_col_beatctr.sv
module burst_col_beatctr #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             halt,
  input  logic [COL_W-1:0] run_mask,
  input  logic             run_row,
  output logic [COL_W-1:0] beat_cnt,
  output logic             beat_valid,
  output logic             beat_last
);
  assign beat_last = beat_valid & ~run_row & (beat_cnt == run_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_cnt   <= '0;
      beat_valid <= 1'b0;
    end else if (load) begin
      beat_cnt   <= '0;
      beat_valid <= 1'b1;
    end else if (halt || beat_last) begin
      beat_valid <= 1'b0;
    end else if (beat_valid) begin
      beat_cnt   <= beat_cnt + COL_W'(1);  // wraps over the row in full-row mode
    end
  end
endmodule

// File: rtl/burst_col_addrgen.sv
module burst_col_addrgen #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] cnt,
  input  logic [COL_W-1:0] mask,
  input  logic             il,
  output logic [COL_W-1:0] col
);
  function automatic logic [COL_W-1:0] beat_col(
    input logic [COL_W-1:0] b, input logic [COL_W-1:0] c,
    input logic [COL_W-1:0] m, input logic x);
    logic [COL_W-1:0] off;
    off = x ? (b ^ c) : (b + c);
    return (b & ~m) | (off & m);
  endfunction

  assign col = beat_col(base, cnt, mask, il);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             interleave,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last,
  output logic             len_err
);
  logic [COL_W-1:0] dec_mask, run_mask, run_base, beat_cnt;
  logic             dec_il, dec_row, dec_bad;
  logic             run_il, run_row;

  burst_col_lendec #(.COL_W(COL_W)) u_dec (
    .code(len_code), .il_req(interleave),
    .mask(dec_mask), .il_eff(dec_il), .row(dec_row), .bad(dec_bad));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_base <= '0;
      run_mask <= '0;
      run_il   <= 1'b0;
      run_row  <= 1'b0;
      len_err  <= 1'b0;
    end else if (start) begin
      run_base <= start_col;
      run_mask <= dec_mask;
      run_il   <= dec_il;
      run_row  <= dec_row;
      len_err  <= dec_bad;
    end
  end

  burst_col_beatctr #(.COL_W(COL_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(start), .halt(stop),
    .run_mask(run_mask), .run_row(run_row),
    .beat_cnt(beat_cnt), .beat_valid(col_valid), .beat_last(col_last));

  burst_col_addrgen #(.COL_W(COL_W)) u_gen (
    .base(run_base), .cnt(beat_cnt), .mask(run_mask), .il(run_il), .col(col_out));
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       len_code,
  input logic             stop,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             col_last,
  input logic             len_err,
  input logic             run_row
);
  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col_out == $past(start_col)));

  a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !start) |=> !col_valid);

  a_r6_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  a_r7_row_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    run_row |-> !col_last);

  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !col_valid);

  a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !run_row && !start && !stop && !col_last)
      |=> (col_valid && col_out[COL_W-1:3] == $past(col_out[COL_W-1:3])));

  a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (len_code == 3'd4 || len_code == 3'd5 || len_code == 3'd6))
      |=> (len_err && col_last));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
  .len_code(len_code), .stop(stop), .col_out(col_out), .col_valid(col_valid),
  .col_last(col_last), .len_err(len_err), .run_row(run_row));

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
module sim_burst_col_seq;
  localparam int COL_W = 9;
  localparam int ROW   = 1 << COL_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, interleave = 1'b0, stop = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0] len_code = 3'd0;
  logic [COL_W-1:0] col_out;
  logic col_valid, col_last, len_err;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .interleave(interleave), .stop(stop),
    .col_out(col_out), .col_valid(col_valid), .col_last(col_last), .len_err(len_err));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_col(input int col, input int n, input int il, input int i);
    int blk, off;
    if (n == ROW) return (col + i) % ROW;
    blk = col - (col % n);
    off = col % n;
    return il ? blk + (off ^ i) : blk + ((off + i) % n);
  endfunction

  // drive at a falling edge; on return the first beat is visible
  task automatic kick(input int col, input int code, input int il);
    start = 1'b1; start_col = COL_W'(col); len_code = 3'(code); interleave = il[0];
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_bounded(input int col, input int code, input int il);
    int n;
    n = 1 << code;
    kick(col, code, il);
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      chk(il ? "R5 interleaved col" : "R4 sequential col", col_out, exp_col(col, n, il, i));
      chk("R3 valid in burst", col_valid, 1);
      chk("R6 last flag", col_last, (i == n - 1) ? 1 : 0);
      chk("R10 err clear", len_err, 0);
    end
    @(negedge clk);
    chk("R6 valid drops after last", col_valid, 0);
  endtask

  initial begin
    #(10 * 200000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", col_valid, 0);
    chk("R1 reset last", col_last, 0);
    chk("R1 reset err", len_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6: sweep lengths, orderings and start offsets
    for (int code = 0; code < 4; code++)
      for (int il = 0; il < 2; il++)
        for (int k = 0; k < 16; k++)
          run_bounded((k * 73) % ROW, code, il);

    // R7: full row, ordering bit ignored, wraps, no last; R8 stop
    kick(9'h0F3, 7, 1);
    for (int i = 0; i < ROW + 8; i++) begin
      if (i > 0) @(negedge clk);
      chk("R7 row col", col_out, exp_col(9'h0F3, ROW, 1, i));
      chk("R7 row no last", col_last, 0);
      chk("R7 row valid", col_valid, 1);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 stop clears valid", col_valid, 0);
    @(negedge clk);
    chk("R8 stays idle", col_valid, 0);

    // R8: stop during bounded burst
    kick(9'h040, 3, 0);
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 stop mid burst", col_valid, 0);

    // R8 R9: start and stop together, start wins
    kick(9'h1FE, 7, 0);
    @(negedge clk);
    stop = 1'b1;
    kick(9'h025, 2, 1);
    stop = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (i > 0) @(negedge clk);
      chk("R8 start beats stop col", col_out, exp_col(9'h025, 4, 1, i));
      chk("R8 start beats stop valid", col_valid, 1);
      chk("R9 last", col_last, (i == 3) ? 1 : 0);
    end
    @(negedge clk);
    chk("R9 ends", col_valid, 0);

    // R9: truncate an 8-beat burst after three beats
    kick(9'h10D, 3, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R9 pre col", col_out, exp_col(9'h10D, 8, 0, 2));
    kick(9'h0B2, 1, 0);
    chk("R9 restart col", col_out, 9'h0B2);
    chk("R9 restart last", col_last, 0);
    @(negedge clk);
    chk("R9 second beat", col_out, 9'h0B3);
    chk("R9 second last", col_last, 1);
    @(negedge clk);
    chk("R9 ends", col_valid, 0);

    // R10: reserved codes
    for (int code = 4; code < 7; code++) begin
      kick(9'h133, code, 0);
      chk("R10 col", col_out, 9'h133);
      chk("R10 single last", col_last, 1);
      chk("R10 err set", len_err, 1);
      @(negedge clk);
      chk("R10 single beat", col_valid, 0);
      chk("R10 err held", len_err, 1);
    end
    kick(9'h007, 0, 0);
    chk("R10 err cleared by start", len_err, 0);
    chk("R3 len1 last", col_last, 1);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule